// File: doc/BRIEF.md
# Hit Triplet Geometric Preselector

This block collects the pixel hits of one readout time frame from three tracker layers. Each hit carries a signed z coordinate and an unsigned azimuth code. The block then walks through every combination of one hit per layer, so the work grows as the cube of the hits per layer. A triplet survives only if two pairwise tests pass. The first test compares layer 1 against layer 0. The second compares layer 2 against layer 1. Each test checks the z step and the azimuth step against programmable signed windows. Only the three hit indices of a surviving triplet go downstream, tagged with the frame number. The coordinates themselves are not sent.

Hits enter as a stream of words, and an end-of-frame word starts the enumeration. While the enumeration runs, the hit input is held off. The loop order is layer 0 outermost and layer 2 innermost, and one combination is examined per clock. When the layer 0/1 pair fails, the whole innermost loop for that pair is skipped. The triplet output is a valid/ready stream, and back-pressure freezes the enumeration without losing anything. A one-cycle done pulse marks the end of each frame.

Top module: `triplet_presel`

## Requirements
- R1: After reset, trip_valid and frame_done are 0, hit_ready is 1 and trip_frame is 0.
- R2: Hit indices are the 0-based arrival order within a layer. With all windows open, a frame with n0, n1 and n2 hits on layers 0, 1 and 2 yields n0·n1·n2 triplets. They come out with i0 outermost and i2 innermost, in increasing order.
- R3: The layer 0/1 z test passes when lo ≤ z1−z0 ≤ hi. The subtraction is signed and both bounds are inclusive.
- R4: The azimuth step is (φb−φa) modulo 1024, read as a signed 10-bit value, and then taken as a magnitude. A magnitude of 512 stays 512. For example, φ0=1020 and φ1=3 give 7.
- R5: The layer 1/2 test applies the same z and azimuth rules to z2−z1 and φ2−φ1, each with its own window.
- R6: A triplet is emitted only when all four window checks pass. Windows are written through cfg_we, cfg_addr and cfg_data. Address 0/1 holds the z01 min/max, 2/3 the φ01 min/max, 4/5 the z12 min/max and 6/7 the φ12 min/max. Reset opens every window fully.
- R7: While trip_valid is 1 and trip_ready is 0, trip_valid stays 1 and the index and frame fields hold steady. No triplet is lost or repeated.
- R8: hit_ready is 0 from the clock after an end-of-frame word is accepted until frame_done. frame_done is a one-cycle pulse in the cycle after the enumeration ends. If a layer is empty, the pulse comes in the cycle after the end-of-frame word.
- R9: trip_frame counts frames from 0 and steps by one with each frame_done. Triplets carry the number of the frame they belong to.
- R10: A layer keeps at most 16 hits per frame, and further hits on it are dropped. Hits with layer code 3 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit word valid |
| hit_ready | output | 1 | Hit word accepted (collecting) |
| hit_eof | input | 1 | Word is an end-of-frame marker, carries no hit |
| hit_layer | input | 2 | Layer code 0..2 (3 ignored) |
| hit_z | input | 10 | Signed z coordinate |
| hit_phi | input | 10 | Unsigned azimuth code, wraps at 1024 |
| cfg_we | input | 1 | Window register write strobe |
| cfg_addr | input | 3 | Window register select |
| cfg_data | input | 12 | Signed window limit |
| trip_valid | output | 1 | Triplet output valid |
| trip_ready | input | 1 | Downstream accepts triplet |
| trip_frame | output | 8 | Current frame number |
| trip_i0 | output | 4 | Layer 0 hit index |
| trip_i1 | output | 4 | Layer 1 hit index |
| trip_i2 | output | 4 | Layer 2 hit index |
| frame_done | output | 1 | One-cycle end-of-enumeration pulse |

## Verification
Two things can land in the same cycle: the final triplet handshake of one frame and the reopening of the hit input for the next frame. The bench sends a second frame right behind the first and holds the first hit word of the second frame valid while the first frame is still enumerating under random back-pressure. It then checks that this hit is taken only once frame_done fires. It also checks that the second frame's triplets carry the next frame number and keep their expected order, with none lost or duplicated.

// File: rtl/triplet_presel.sv
module triplet_presel #(
  parameter int Z_W     = 10,
  parameter int PHI_W   = 10,
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LIM_W  = (Z_W > PHI_W ? Z_W : PHI_W) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_valid,
  output logic               hit_ready,
  input  logic               hit_eof,
  input  logic [1:0]         hit_layer,
  input  logic [Z_W-1:0]     hit_z,
  input  logic [PHI_W-1:0]   hit_phi,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [LIM_W-1:0]   cfg_data,
  output logic               trip_valid,
  input  logic               trip_ready,
  output logic [FRAME_W-1:0] trip_frame,
  output logic [IDX_W-1:0]   trip_i0,
  output logic [IDX_W-1:0]   trip_i1,
  output logic [IDX_W-1:0]   trip_i2,
  output logic               frame_done
);

  logic signed [Z_W-1:0] zmem [3][DEPTH];
  logic [PHI_W-1:0]      pmem [3][DEPTH];
  logic [CNT_W-1:0]      cnt  [3];
  logic signed [LIM_W-1:0] win [8];
  logic busy, done_q;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0] i0, i1, i2;

  function automatic logic inwin(input logic signed [LIM_W-1:0] v, lo, hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic signed [LIM_W-1:0] zstep(input logic signed [Z_W-1:0] a, b);
    logic signed [LIM_W-1:0] ea, eb;
    ea = LIM_W'(a);
    eb = LIM_W'(b);
    return eb - ea;
  endfunction

  function automatic logic signed [LIM_W-1:0] pstep(input logic [PHI_W-1:0] a, b);
    logic [PHI_W-1:0] d;
    d = b - a;
    if (d[PHI_W-1]) d = ~d + PHI_W'(1);
    return $signed({{(LIM_W-PHI_W){1'b0}}, d});
  endfunction

  logic p01, p12, last0, last1, last2, adv, end1, end2, end0;

  assign p01 = inwin(zstep(zmem[0][i0], zmem[1][i1]), win[0], win[1]) &&
               inwin(pstep(pmem[0][i0], pmem[1][i1]), win[2], win[3]);
  assign p12 = inwin(zstep(zmem[1][i1], zmem[2][i2]), win[4], win[5]) &&
               inwin(pstep(pmem[1][i1], pmem[2][i2]), win[6], win[7]);

  assign last0 = (CNT_W'(i0) + CNT_W'(1)) == cnt[0];
  assign last1 = (CNT_W'(i1) + CNT_W'(1)) == cnt[1];
  assign last2 = (CNT_W'(i2) + CNT_W'(1)) == cnt[2];

  assign hit_ready  = !busy;
  assign trip_valid = busy && p01 && p12;
  assign adv        = busy && (!trip_valid || trip_ready);
  assign end2       = !p01 || last2;
  assign end1       = end2 && last1;
  assign end0       = end1 && last0;

  assign trip_frame = frame;
  assign trip_i0    = i0;
  assign trip_i1    = i1;
  assign trip_i2    = i2;
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      frame  <= '0;
      i0 <= '0; i1 <= '0; i2 <= '0;
      for (int l = 0; l < 3; l++) cnt[l] <= '0;
      for (int w = 0; w < 8; w++)
        win[w] <= (w % 2 == 0) ? {1'b1, {(LIM_W-1){1'b0}}} : {1'b0, {(LIM_W-1){1'b1}}};
    end else begin
      done_q <= 1'b0;
      if (cfg_we) win[cfg_addr] <= $signed(cfg_data);
      if (!busy && hit_valid) begin
        if (hit_eof) begin
          i0 <= '0; i1 <= '0; i2 <= '0;
          if (cnt[0] != '0 && cnt[1] != '0 && cnt[2] != '0) begin
            busy <= 1'b1;
          end else begin
            done_q <= 1'b1;
            frame  <= frame + FRAME_W'(1);
            for (int l = 0; l < 3; l++) cnt[l] <= '0;
          end
        end else begin
          for (int l = 0; l < 3; l++)
            if (hit_layer == 2'(l) && cnt[l] < CNT_W'(DEPTH)) begin
              zmem[l][IDX_W'(cnt[l])] <= hit_z;
              pmem[l][IDX_W'(cnt[l])] <= hit_phi;
              cnt[l] <= cnt[l] + CNT_W'(1);
            end
        end
      end
      if (adv) begin
        if (end2) begin
          i2 <= '0;
          if (end1) begin
            i1 <= '0;
            if (end0) begin
              i0     <= '0;
              busy   <= 1'b0;
              done_q <= 1'b1;
              frame  <= frame + FRAME_W'(1);
              for (int l = 0; l < 3; l++) cnt[l] <= '0;
            end else i0 <= i0 + IDX_W'(1);
          end else i1 <= i1 + IDX_W'(1);
        end else i2 <= i2 + IDX_W'(1);
      end
    end
  end

  // R8
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_valid |-> !hit_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_valid && !trip_ready |=> trip_valid && $stable({trip_frame, trip_i0, trip_i1, trip_i2}));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> trip_frame == FRAME_W'($past(trip_frame) + FRAME_W'(1)));

  // R10
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_valid |-> (CNT_W'(trip_i0) < cnt[0]) && (CNT_W'(trip_i1) < cnt[1]) && (CNT_W'(trip_i2) < cnt[2]));

endmodule

// File: tb/triplet_presel_tb_top.sv
module triplet_presel_tb_top;
  logic clk = 0, rst_n = 0;
  logic hit_valid = 0, hit_eof = 0, cfg_we = 0, trip_ready = 0;
  logic [1:0] hit_layer = 0;
  logic [9:0] hit_z = 0, hit_phi = 0;
  logic [2:0] cfg_addr = 0;
  logic [11:0] cfg_data = 0;
  logic hit_ready, trip_valid, frame_done;
  logic [7:0] trip_frame;
  logic [3:0] trip_i0, trip_i1, trip_i2;

  triplet_presel dut_i (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [19:0] expq[$];
  int lo[4], hi[4];
  int hz[3][24], hp[3][24], hn[3];
  int frames_sent = 0, done_cnt = 0;
  bit rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic int pabs(int a, int b);
    int d = ((b - a) % 1024 + 1024) % 1024;
    return (d >= 512) ? 1024 - d : d;
  endfunction

  function automatic bit pair_ok(int la, int a, int b, int k);
    int dz = hz[la+1][b] - hz[la][a];
    int dp = pabs(hp[la][a], hp[la+1][b]);
    return dz >= lo[k] && dz <= hi[k] && dp >= lo[k+1] && dp <= hi[k+1];
  endfunction

  task automatic send_word(input int l, input int z, input int p, input bit eof);
    @(negedge clk);
    hit_valid = 1; hit_eof = eof; hit_layer = 2'(l); hit_z = 10'(z); hit_phi = 10'(p);
    while (!hit_ready) @(negedge clk);
    @(negedge clk);
    hit_valid = 0; hit_eof = 0;
  endtask

  // pushes expected triplets, then streams hits; extra adds an ignored layer-3 hit (R10)
  task automatic send_frame(input bit extra);
    int c[3];
    int mx;
    for (int l = 0; l < 3; l++) c[l] = (hn[l] > 16) ? 16 : hn[l];
    for (int a = 0; a < c[0]; a++)
      for (int b = 0; b < c[1]; b++)
        if (pair_ok(0, a, b, 0))
          for (int d = 0; d < c[2]; d++)
            if (pair_ok(1, b, d, 2))
              expq.push_back({8'(frames_sent), 4'(a), 4'(b), 4'(d)});
    mx = hn[0];
    if (hn[1] > mx) mx = hn[1];
    if (hn[2] > mx) mx = hn[2];
    for (int k = 0; k < mx; k++)
      for (int l = 0; l < 3; l++)
        if (k < hn[l]) send_word(l, hz[l][k], hp[l][k], 0);
    if (extra) send_word(3, 0, 0, 0);
    send_word(0, 0, 0, 1);
    frames_sent++;
  endtask

  task automatic wait_idle();
    while (done_cnt != frames_sent) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int k, input int l, input int h);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(2*k); cfg_data = 12'(l);
    @(negedge clk);
    cfg_addr = 3'(2*k+1); cfg_data = 12'(h);
    @(negedge clk);
    cfg_we = 0;
    lo[k] = l; hi[k] = h;
  endtask

  task automatic fill(input int n0, input int n1, input int n2, input int zr, input int pr);
    hn[0] = n0; hn[1] = n1; hn[2] = n2;
    for (int l = 0; l < 3; l++)
      for (int k = 0; k < hn[l]; k++) begin
        hz[l][k] = $urandom_range(zr) - zr/2;
        hp[l][k] = ($urandom_range(pr) + 1000) % 1024;
      end
  endtask

  // monitor / scoreboard
  initial begin
    logic [19:0] held, got, e;
    bit stalled = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        got = {trip_frame, trip_i0, trip_i1, trip_i2};
        if (stalled) check(trip_valid && got == held, "R7 stall hold", int'(got), int'(held));
        trip_ready = rand_ready ? lfsr[0] : 1'b1;
        if (trip_valid && trip_ready) begin
          if (expq.size() == 0) check(0, "R6 unexpected triplet", int'(got), -1);
          else begin
            e = expq.pop_front();
            check(got == e, "R2/R6/R9 triplet", int'(got), int'(e));
          end
        end
        stalled = trip_valid && !trip_ready;
        held = got;
        if (frame_done) begin
          done_cnt++;
          check(trip_frame == 8'(done_cnt), "R9 frame count", trip_frame, done_cnt);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R8 watchdog timeout", 0, 1);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin lo[k] = -2048; hi[k] = 2047; end
    repeat (3) @(negedge clk);
    // R1
    check(!trip_valid && !frame_done && hit_ready && trip_frame == 0, "R1 reset state",
          {trip_valid, frame_done, hit_ready}, 1);
    rst_n = 1;
    @(negedge clk);

    // R2: open windows, full ordered enumeration
    fill(3, 2, 2, 40, 50);
    send_frame(0);
    wait_idle();
    check(expq.size() == 0, "R2 all 12 emitted", expq.size(), 0);

    // R3/R4/R5: tight windows, back-to-back frames under back-pressure (R7, R8)
    cfg(0, -10, 15);
    cfg(1, 2, 20);
    cfg(2, -12, 8);
    cfg(3, 0, 25);
    rand_ready = 1;
    fill(6, 5, 6, 60, 60);
    send_frame(0);
    fill(5, 6, 4, 60, 60);
    send_frame(0);
    wait_idle();
    check(expq.size() == 0, "R3 R5 R6 R7 windowed frames", expq.size(), 0);

    // R4: phi wrap 1020 -> 3 gives 7
    cfg(0, -5, 5); cfg(2, -2047, 2047); cfg(3, 0, 2047);
    cfg(1, 0, 7);
    hn[0] = 1; hn[1] = 1; hn[2] = 1;
    hz[0][0] = 0; hz[1][0] = 0; hz[2][0] = 0;
    hp[0][0] = 1020; hp[1][0] = 3; hp[2][0] = 3;
    send_frame(0);
    wait_idle();
    check(expq.size() == 0, "R4 wrap pass at 7", expq.size(), 0);
    cfg(1, 0, 6);
    send_frame(0);
    wait_idle();
    check(expq.size() == 0, "R4 wrap fail at 6", expq.size(), 0);
    // R3 inclusive z bounds
    cfg(1, 0, 2047);
    hz[1][0] = 5;
    send_frame(0);
    hz[1][0] = 6;
    send_frame(0);
    wait_idle();
    check(expq.size() == 0, "R3 inclusive z edge", expq.size(), 0);

    // R10: 18 hits on layer 0, one ignored layer-3 hit
    for (int k = 0; k < 4; k++) cfg(k, -2048, 2047);
    rand_ready = 0;
    fill(18, 1, 1, 20, 20);
    send_frame(1);
    wait_idle();
    check(expq.size() == 0, "R10 capped at 16", expq.size(), 0);

    // R8: empty layer -> immediate frame_done, nothing emitted
    fill(2, 0, 3, 20, 20);
    send_frame(0);
    wait_idle();
    check(expq.size() == 0 && hit_ready, "R8 empty layer frame", expq.size(), 0);
    check(trip_frame == 8'(frames_sent), "R9 final frame number", trip_frame, frames_sent);
    finish_run();
  end
endmodule